// File: doc/BRIEF.md
# Request-Framed Byte Serial Port

This block is a half-duplex, byte-wide serial port that sits between a host controller and a system-side datapath. The host supplies the bit clock and a request line; bits move only while the request is active. In receive mode the port assembles 8-bit words from the shared data line, for example a compressed audio bitstream or voice samples. In transmit mode it shifts bytes supplied by the system side onto the same line.

All serial inputs are oversampled in the fast system clock domain. Edges of the external bit clock are detected after a synchronizer. Receive data is captured on a detected rising edge. Transmit data is updated on a detected falling edge, so it is steady when the far end samples. One configuration input selects whether the least or the most significant bit travels first, and the choice applies to both directions. When the request line drops, any partly assembled word is thrown away.

Top module: `byte_serial_port`

## Requirements
- R1: After reset, rx_valid, rx_overrun, tx_underrun, ser_dat_o and ser_dat_oe are all 0, and tx_ready is 1.
- R2: With cfg_msb_first = 0 in receive mode (cfg_tx_mode = 0), the first bit sampled in a word becomes bit 0 of rx_byte and the eighth becomes bit 7.
- R3: With cfg_msb_first = 1 in receive mode, the first bit sampled in a word becomes bit 7 of rx_byte and the eighth becomes bit 0.
- R4: Each completed 8-bit word raises rx_valid for exactly one system cycle, with rx_byte holding the word. In transmit mode rx_valid never rises.
- R5: When ser_req_i goes low before 8 bits have arrived, the partial word is discarded. The next word starts counting from its first bit again, and the partial word produces no rx_valid.
- R6: rx_overrun pulses together with rx_valid when a word completes while the previous word has not been acknowledged through rx_ack.
- R7: In transmit mode, ser_dat_oe is 1 while the request is active. Bytes leave LSB-first when cfg_msb_first = 0 and MSB-first when cfg_msb_first = 1. ser_dat_oe is 0 in receive mode.
- R8: In transmit mode, ser_dat_o changes only after a falling edge of the bit clock (or at the start of a request), and holds its value throughout each high phase of the bit clock.
- R9: If no byte is waiting when a transmit word begins, the line carries 0 for the whole word and tx_underrun pulses for one cycle. A word begins when the request rises, or at the falling edge that follows the eighth rising edge.
- R10: While ser_req_i is low, no bits move: bit-clock toggles produce no rx_valid, and ser_dat_oe and ser_dat_o stay 0.
- R11: tx_ready is 1 while the one-byte transmit holding register is empty. A byte is taken when tx_valid and tx_ready are both 1, which drops tx_ready. The holding register empties again when a word start loads its byte into the shifter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Externally generated serial bit clock |
| ser_req_i | input | 1 | Host request line, active high; frames transfers |
| ser_dat_i | input | 1 | Serial data line, receive side |
| ser_dat_o | output | 1 | Serial data line, transmit side |
| ser_dat_oe | output | 1 | Drive enable for the shared data line |
| cfg_msb_first | input | 1 | 1 = MSB first, 0 = LSB first (both directions) |
| cfg_tx_mode | input | 1 | 1 = transmit, 0 = receive |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a new rx_byte |
| rx_ack | input | 1 | System side accepts the pending received byte |
| rx_overrun | output | 1 | One-cycle pulse: a byte completed before the previous one was acknowledged |
| tx_byte | input | 8 | Byte offered for transmission |
| tx_valid | input | 1 | tx_byte is valid |
| tx_ready | output | 1 | Holding register can take a byte |
| tx_underrun | output | 1 | One-cycle pulse: a transmit word started with no byte waiting |

## Verification
The hardest case to reach is the back-to-back transmit boundary. The byte for the second word must already be in the holding register when the falling edge after the eighth rising edge arrives. That falling edge is also what shifts nothing and starts the next word. The bench raises the request, waits for the first byte to move into the shifter, pushes the second byte during the first word, and checks both words bit by bit at each rising edge. A partial-word abort is reached by dropping the request after five bits. Because the following full word must then decode exactly, a counter that failed to clear would surface as a wrong byte.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  localparam int unsigned BSP_WORD_W      = 8;
  localparam int unsigned BSP_SYNC_STAGES = 2;

  typedef enum logic {
    ORDER_LSB_FIRST = 1'b0,
    ORDER_MSB_FIRST = 1'b1
  } bit_order_e;
endpackage

// File: rtl/bsp_sync.sv
module bsp_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/bsp_rx.sv
module bsp_rx
  import bsp_pkg::*;
#(
  parameter int unsigned WORD_W = BSP_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_rise,
  input  logic              req_on,
  input  logic              rx_mode,
  input  bit_order_e        order,
  input  logic              din,
  input  logic              ack,
  output logic [WORD_W-1:0] byte_o,
  output logic              valid_o,
  output logic              overrun_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shreg, shreg_nx;
  logic [CNT_W-1:0]  bit_cnt;
  logic              pending;
  logic              active;

  assign active = req_on & rx_mode;

  always_comb begin
    if (order == ORDER_MSB_FIRST) shreg_nx = {shreg[WORD_W-2:0], din};
    else                          shreg_nx = {din, shreg[WORD_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      bit_cnt   <= '0;
      byte_o    <= '0;
      valid_o   <= 1'b0;
      overrun_o <= 1'b0;
      pending   <= 1'b0;
    end else begin
      valid_o   <= 1'b0;
      overrun_o <= 1'b0;
      if (pending && ack) pending <= 1'b0;
      if (!active) begin
        bit_cnt <= '0;
        shreg   <= '0;
      end else if (bit_rise) begin
        shreg <= shreg_nx;
        if (bit_cnt == LAST_BIT) begin
          bit_cnt   <= '0;
          byte_o    <= shreg_nx;
          valid_o   <= 1'b1;
          pending   <= 1'b1;
          overrun_o <= pending & ~ack;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bsp_tx.sv
module bsp_tx
  import bsp_pkg::*;
#(
  parameter int unsigned WORD_W = BSP_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_rise,
  input  logic              bit_fall,
  input  logic              req_on,
  input  logic              tx_mode,
  input  bit_order_e        order,
  input  logic [WORD_W-1:0] tx_byte,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              dat_o,
  output logic              oe_o,
  output logic              underrun_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] hold, shreg, src, shreg_nx;
  logic              hold_empty;
  logic [CNT_W-1:0]  bit_cnt;
  logic              loaded, active, act_q, start, load, shift;
  logic              src_head, nx_head;

  assign active = req_on & tx_mode;
  assign start  = active & ~act_q;
  assign load   = active & ~loaded & (bit_fall | start);
  assign shift  = active & loaded & bit_fall & (bit_cnt != '0);
  assign src    = hold_empty ? '0 : hold;
  assign tx_ready = hold_empty;

  always_comb begin
    if (order == ORDER_MSB_FIRST) begin
      shreg_nx = {shreg[WORD_W-2:0], 1'b0};
      src_head = src[WORD_W-1];
      nx_head  = shreg_nx[WORD_W-1];
    end else begin
      shreg_nx = {1'b0, shreg[WORD_W-1:1]};
      src_head = src[0];
      nx_head  = shreg_nx[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold       <= '0;
      hold_empty <= 1'b1;
    end else begin
      if (load && !hold_empty) hold_empty <= 1'b1;
      if (tx_valid && hold_empty) begin
        hold       <= tx_byte;
        hold_empty <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q      <= 1'b0;
      oe_o       <= 1'b0;
      underrun_o <= 1'b0;
      loaded     <= 1'b0;
      bit_cnt    <= '0;
      shreg      <= '0;
      dat_o      <= 1'b0;
    end else begin
      act_q      <= active;
      oe_o       <= active;
      underrun_o <= 1'b0;
      if (!active) begin
        loaded  <= 1'b0;
        bit_cnt <= '0;
        shreg   <= '0;
        dat_o   <= 1'b0;
      end else begin
        if (load) begin
          loaded     <= 1'b1;
          shreg      <= src;
          dat_o      <= src_head;
          underrun_o <= hold_empty;
        end else if (shift) begin
          shreg <= shreg_nx;
          dat_o <= nx_head;
        end
        if (bit_rise && loaded) begin
          if (bit_cnt == LAST_BIT) begin
            bit_cnt <= '0;
            loaded  <= 1'b0;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/byte_serial_port.sv
module byte_serial_port
  import bsp_pkg::*;
#(
  parameter int unsigned WORD_W      = BSP_WORD_W,
  parameter int unsigned SYNC_STAGES = BSP_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk_i,
  input  logic              ser_req_i,
  input  logic              ser_dat_i,
  output logic              ser_dat_o,
  output logic              ser_dat_oe,
  input  logic              cfg_msb_first,
  input  logic              cfg_tx_mode,
  output logic [WORD_W-1:0] rx_byte,
  output logic              rx_valid,
  input  logic              rx_ack,
  output logic              rx_overrun,
  input  logic [WORD_W-1:0] tx_byte,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              tx_underrun
);
  localparam int unsigned LINE_W = 3;

  logic [LINE_W-1:0] line_raw, line_sync;
  logic              sclk_s, sreq_s, sdat_s, sclk_q;
  logic              bit_rise, bit_fall;
  bit_order_e        order;

  assign line_raw = {ser_clk_i, ser_req_i, ser_dat_i};

  bsp_sync #(.WIDTH(LINE_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (line_raw),
    .sync_o  (line_sync)
  );

  assign {sclk_s, sreq_s, sdat_s} = line_sync;

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= sclk_s;
  end

  assign bit_rise = sclk_s & ~sclk_q;
  assign bit_fall = ~sclk_s & sclk_q;
  assign order    = bit_order_e'(cfg_msb_first);

  bsp_rx #(.WORD_W(WORD_W)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .bit_rise  (bit_rise),
    .req_on    (sreq_s),
    .rx_mode   (~cfg_tx_mode),
    .order     (order),
    .din       (sdat_s),
    .ack       (rx_ack),
    .byte_o    (rx_byte),
    .valid_o   (rx_valid),
    .overrun_o (rx_overrun)
  );

  bsp_tx #(.WORD_W(WORD_W)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .bit_rise   (bit_rise),
    .bit_fall   (bit_fall),
    .req_on     (sreq_s),
    .tx_mode    (cfg_tx_mode),
    .order      (order),
    .tx_byte    (tx_byte),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .dat_o      (ser_dat_o),
    .oe_o       (ser_dat_oe),
    .underrun_o (tx_underrun)
  );
endmodule

// File: rtl/byte_serial_port_chk.sv
module byte_serial_port_chk (
  input logic clk,
  input logic rst,
  input logic cfg_tx_mode,
  input logic rx_valid,
  input logic rx_overrun,
  input logic ser_dat_o,
  input logic ser_dat_oe,
  input logic tx_valid,
  input logic tx_ready,
  input logic tx_underrun
);
  // R4
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  // R4
  valid_rx_only_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> !$past(cfg_tx_mode));
  // R6
  overrun_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rx_overrun |-> rx_valid);
  // R7
  oe_tx_only_chk: assert property (@(posedge clk) disable iff (rst)
    ser_dat_oe |-> $past(cfg_tx_mode));
  // R9
  underrun_low_chk: assert property (@(posedge clk) disable iff (rst)
    tx_underrun |-> !ser_dat_o);
  // R10
  quiet_line_chk: assert property (@(posedge clk) disable iff (rst)
    !ser_dat_oe |-> !ser_dat_o);
  // R11
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_ready) |-> $past(tx_valid));
endmodule

bind byte_serial_port byte_serial_port_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_tx_mode (cfg_tx_mode),
  .rx_valid    (rx_valid),
  .rx_overrun  (rx_overrun),
  .ser_dat_o   (ser_dat_o),
  .ser_dat_oe  (ser_dat_oe),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .tx_underrun (tx_underrun)
);

// File: tb/tb_byte_serial_port.sv
`timescale 1ns/1ps
module tb_byte_serial_port;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_req = 1'b0, ser_din = 1'b0;
  logic ser_dat_o, ser_dat_oe;
  logic cfg_msb_first = 1'b0, cfg_tx_mode = 1'b0;
  logic [7:0] rx_byte;
  logic rx_valid, rx_overrun;
  logic rx_ack = 1'b1;
  logic [7:0] tx_byte = '0;
  logic tx_valid = 1'b0;
  logic tx_ready, tx_underrun;

  int checks = 0, fails = 0;
  int n_valid = 0, n_over = 0, n_under = 0;
  logic [7:0] last_rx = '0;

  always #2 clk = ~clk;

  byte_serial_port dut (
    .clk(clk), .rst(rst),
    .ser_clk_i(ser_clk), .ser_req_i(ser_req), .ser_dat_i(ser_din),
    .ser_dat_o(ser_dat_o), .ser_dat_oe(ser_dat_oe),
    .cfg_msb_first(cfg_msb_first), .cfg_tx_mode(cfg_tx_mode),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ack(rx_ack), .rx_overrun(rx_overrun),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_underrun(tx_underrun)
  );

  always @(negedge clk) begin
    if (rx_valid) begin n_valid++; last_rx = rx_byte; end
    if (rx_overrun) n_over++;
    if (tx_underrun) n_under++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_sys(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  // bits[i] is the i-th bit on the wire; seen[i] is the line sampled before rise i
  task automatic run_bits(input int n, input logic [7:0] bits,
                          output logic [7:0] seen, inout int unstable);
    seen = '0;
    for (int i = 0; i < n; i++) begin
      ser_din = bits[i];
      wait_sys(HALF);
      seen[i] = ser_dat_o;
      ser_clk = 1'b1;
      wait_sys(HALF);
      if (ser_dat_o !== seen[i]) unstable++;
      ser_clk = 1'b0;
    end
    wait_sys(HALF);
  endtask

  task automatic push(input logic [7:0] b);
    tx_byte  = b;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic t_reset();
    check(rx_valid == 0 && rx_overrun == 0 && tx_underrun == 0, "R1", "rx/tx strobes",
          {rx_valid, rx_overrun, tx_underrun}, 0);
    check(ser_dat_o == 0 && ser_dat_oe == 0, "R1", "line outputs", {ser_dat_o, ser_dat_oe}, 0);
    check(tx_ready == 1, "R1", "tx_ready", tx_ready, 1);
  endtask

  task automatic t_rx_lsb();
    logic [7:0] s; int u = 0; int v0 = n_valid;
    cfg_tx_mode = 0; cfg_msb_first = 0; ser_req = 1; wait_sys(HALF);
    run_bits(8, 8'hA5, s, u);
    check(n_valid == v0 + 1, "R4", "one valid per word", n_valid - v0, 1);
    check(last_rx == 8'hA5, "R2", "lsb-first byte", last_rx, 8'hA5);
    run_bits(8, 8'h3C, s, u);
    check(last_rx == 8'h3C, "R2", "lsb-first second byte", last_rx, 8'h3C);
    check(n_valid == v0 + 2, "R4", "two words two valids", n_valid - v0, 2);
    ser_req = 0; wait_sys(HALF);
  endtask

  task automatic t_rx_msb();
    logic [7:0] s; int u = 0;
    cfg_tx_mode = 0; cfg_msb_first = 1; ser_req = 1; wait_sys(HALF);
    run_bits(8, rev8(8'hC1), s, u);
    check(last_rx == 8'hC1, "R3", "msb-first byte", last_rx, 8'hC1);
    ser_req = 0; wait_sys(HALF);
  endtask

  task automatic t_rx_abort();
    logic [7:0] s; int u = 0; int v0 = n_valid;
    cfg_tx_mode = 0; cfg_msb_first = 0; ser_req = 1; wait_sys(HALF);
    run_bits(5, 8'hFF, s, u);
    ser_req = 0; wait_sys(2 * HALF);
    check(n_valid == v0, "R5", "no valid for partial word", n_valid - v0, 0);
    ser_req = 1; wait_sys(HALF);
    run_bits(8, 8'h5A, s, u);
    check(n_valid == v0 + 1, "R5", "single valid after abort", n_valid - v0, 1);
    check(last_rx == 8'h5A, "R5", "byte after abort", last_rx, 8'h5A);
    ser_req = 0; wait_sys(HALF);
  endtask

  task automatic t_overrun();
    logic [7:0] s; int u = 0; int o0 = n_over;
    cfg_tx_mode = 0; cfg_msb_first = 0; rx_ack = 0; ser_req = 1; wait_sys(HALF);
    run_bits(8, 8'h11, s, u);
    check(n_over == o0, "R6", "no overrun on first word", n_over - o0, 0);
    run_bits(8, 8'h22, s, u);
    check(n_over == o0 + 1, "R6", "overrun on unacked word", n_over - o0, 1);
    check(last_rx == 8'h22, "R6", "byte with overrun", last_rx, 8'h22);
    rx_ack = 1; ser_req = 0; wait_sys(HALF);
  endtask

  task automatic t_idle();
    logic [7:0] s; int u = 0; int v0 = n_valid;
    cfg_tx_mode = 0; ser_req = 0;
    run_bits(8, 8'hF0, s, u);
    check(n_valid == v0, "R10", "no valid without request", n_valid - v0, 0);
    cfg_tx_mode = 1; wait_sys(4);
    check(ser_dat_oe == 0 && ser_dat_o == 0, "R10", "tx line quiet without request",
          {ser_dat_oe, ser_dat_o}, 0);
    cfg_tx_mode = 0;
  endtask

  task automatic t_tx_lsb();
    logic [7:0] s; int u = 0;
    cfg_tx_mode = 1; cfg_msb_first = 0;
    push(8'h96);
    check(tx_ready == 0, "R11", "ready low when holding full", tx_ready, 0);
    ser_req = 1; wait_sys(HALF);
    check(tx_ready == 1, "R11", "ready back after word start", tx_ready, 1);
    check(ser_dat_oe == 1, "R7", "oe during transmit", ser_dat_oe, 1);
    push(8'h2D);
    check(tx_ready == 0, "R11", "second byte held", tx_ready, 0);
    run_bits(8, 8'h00, s, u);
    check(s == 8'h96, "R7", "lsb-first first word", s, 8'h96);
    run_bits(8, 8'h00, s, u);
    check(s == 8'h2D, "R7", "lsb-first back-to-back word", s, 8'h2D);
    check(u == 0, "R8", "line stable while bit clock high", u, 0);
    ser_req = 0; wait_sys(HALF);
    check(ser_dat_oe == 0 && ser_dat_o == 0, "R10", "line released", {ser_dat_oe, ser_dat_o}, 0);
  endtask

  task automatic t_tx_msb();
    logic [7:0] s; int u = 0;
    cfg_tx_mode = 1; cfg_msb_first = 1;
    push(8'h4E);
    ser_req = 1; wait_sys(HALF);
    run_bits(8, 8'h00, s, u);
    check(s == rev8(8'h4E), "R7", "msb-first word", s, rev8(8'h4E));
    check(u == 0, "R8", "msb-first stability", u, 0);
    ser_req = 0; wait_sys(HALF);
  endtask

  task automatic t_underrun();
    logic [7:0] s; int u = 0; int n0 = n_under; int v0 = n_valid;
    cfg_tx_mode = 1; cfg_msb_first = 0; ser_req = 1; wait_sys(HALF);
    run_bits(8, 8'hFF, s, u);
    check(s == 8'h00, "R9", "line low on underrun", s, 0);
    check(n_under == n0 + 2, "R9", "underrun at start and next boundary", n_under - n0, 2);
    check(n_valid == v0, "R4", "no rx valid in transmit mode", n_valid - v0, 0);
    ser_req = 0; wait_sys(HALF);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    checks++; fails++;
    $display("FAIL watchdog all requirements actual=hung expected=done");
    finish_run();
  end

  initial begin
    wait_sys(5);
    rst = 0;
    wait_sys(2);
    t_reset();
    t_rx_lsb();
    t_rx_msb();
    t_rx_abort();
    t_overrun();
    t_idle();
    t_tx_lsb();
    t_tx_msb();
    t_underrun();
    finish_run();
  end
endmodule